// File: doc/BRIEF.md
# Interrupt Entry Controller

This block decides, on every clock edge, whether the processor core takes an architectural reset, a non-maskable interrupt or one of six maskable interrupt sources. When it takes one, it updates the architectural state on that single edge: the fetch target, the status word, the exception cause register and the saved context registers. In the same cycle it raises a one-cycle redirect strobe towards the fetch stage. The core supplies the current PC. It can rewrite the status word through a write port, and it signals the end of a non-maskable handler with a return strobe.

A rising edge on the non-maskable request sets a single pending flag. While the non-maskable-active flag is set, the interrupt stays pending and is retried every cycle, and further rising edges fold into the same flag. Maskable request lines are level inputs that the requester holds until it sees its acknowledge pulse. They are blocked while either the non-maskable-active flag or the interrupt-disable flag is set. When several are acceptable together, the lowest-numbered source wins.

A four-state machine names the action committed on the last edge:
- ST_RUN: no entry.
- ST_RESET: reset taken.
- ST_NMI: non-maskable entry.
- ST_MASKABLE: maskable entry.

On every edge the next state is chosen from the inputs:
- to ST_RESET when `reset_req` is high;
- else to ST_NMI when a non-maskable interrupt is pending and NP is clear;
- else to ST_MASKABLE when any maskable line is high and NP and ID are both clear;
- else to ST_RUN.

Every state except ST_RUN drives the redirect strobe.

Top module: `irq_entry_ctrl`

## Requirements
- R1: `rst_n` low, and also a cycle with `reset_req` high, leaves `target_pc_o`=0x0, `psw_o`=0x20 and `ecr_o`=0, with no acknowledge. `reset_req` also pulses `redirect_o` one edge later and drops any pending non-maskable interrupt. Status word layout: bit7 NP, bit6 EP, bit5 ID, bit4 SAT, bit3 CY, bit2 OV, bit1 S, bit0 Z.
- R2: When a non-maskable interrupt is taken, the following happen on the next edge:
  - `fepc_o` gets `cur_pc` and `fepsw_o` gets the old status word.
  - `ecr_o` becomes its old low 16 bits OR 0x10, with the upper half zero.
  - NP and ID are set and EP is cleared.
  - `target_pc_o` becomes 0x10.
- R3: While NP is set, no non-maskable entry occurs. The pending flag, set by a rising edge of `nmi_req`, stays until the interrupt is taken. Any number of rising edges while it is pending produce exactly one entry.
- R4: In a cycle with no entry, `nmi_ret` clears NP after any status word write. In a cycle with an entry, both the write and `nmi_ret` are dropped.
- R5: While NP or ID is set, no maskable source is acknowledged and `mi_ack_o` stays 0.
- R6: When maskable source i is taken, the following happen on the next edge:
  - `eipc_o` gets `cur_pc` and `eipsw_o` gets the old status word.
  - ID is set and EP is cleared.
  - `ecr_o[15:0]` gets the source code and `ecr_o[31:16]` is kept.
  - `target_pc_o` gets the same code.
  - `mi_ack_o` is a one-hot pulse with bit i set.
- R7: The code for source i is 0x80 + 0x10*i (0x80 to 0xD0). When several sources are high, the lowest index is taken and the others get no acknowledge.
- R8: Reset takes precedence over a non-maskable interrupt, and a non-maskable interrupt takes precedence over any maskable source.
- R9: In a cycle with no entry, `psw_wr_en` loads all 8 bits of `psw_wr_data` into the status word.
- R10: `redirect_o` is high exactly on the cycles after an entry edge. `target_pc_o`, `fepc_o` and `eipc_o` change only on such edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset to the architectural reset state |
| reset_req | input | 1 | Synchronous architectural reset request |
| nmi_req | input | 1 | Non-maskable request, rising-edge detected |
| nmi_ret | input | 1 | Return from non-maskable handler, clears NP |
| mi_req | input | 6 | Maskable request levels, index 0 has highest priority |
| cur_pc | input | 32 | PC of the instruction being interrupted |
| psw_wr_en | input | 1 | Status word write enable |
| psw_wr_data | input | 8 | Status word write data |
| redirect_o | output | 1 | Fetch redirect strobe |
| target_pc_o | output | 32 | Redirect target |
| psw_o | output | 8 | Status word |
| ecr_o | output | 32 | Exception cause register |
| eipc_o | output | 32 | Saved PC, maskable entry |
| eipsw_o | output | 8 | Saved status word, maskable entry |
| fepc_o | output | 32 | Saved PC, non-maskable entry |
| fepsw_o | output | 8 | Saved status word, non-maskable entry |
| mi_ack_o | output | 6 | One-cycle acknowledge per maskable source |

## Verification
The assertions take for granted that `rst_n` is the only asynchronous input and that all other inputs are stable around the rising edge. The acknowledge assertion assumes a maskable line is held high in the cycle it is taken. The stimulus changes every input on the falling edge only. It raises each maskable pattern for exactly one sampled edge, and it always follows a request cycle with a non-maskable return and an idle cycle, so that any merged pending interrupt drains before the next vector.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int PSW_W = 8;

    // status word bit positions
    localparam int PSW_Z   = 0;
    localparam int PSW_S   = 1;
    localparam int PSW_OV  = 2;
    localparam int PSW_CY  = 3;
    localparam int PSW_SAT = 4;
    localparam int PSW_ID  = 5;
    localparam int PSW_EP  = 6;
    localparam int PSW_NP  = 7;

    localparam logic [PSW_W-1:0] PSW_RESET = 8'h20;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_RESET    = 2'd1,
        ST_NMI      = 2'd2,
        ST_MASKABLE = 2'd3
    } entry_state_e;

endpackage

// File: rtl/irq_nmi_pending.sv
module irq_nmi_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_req,
    input  logic taken,
    input  logic flush,
    output logic live_o
);

    logic req_prev_q;
    logic pend_q;
    logic rise;

    assign rise   = nmi_req & ~req_prev_q;
    assign live_o = pend_q | rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_prev_q <= 1'b0;
            pend_q     <= 1'b0;
        end else begin
            req_prev_q <= nmi_req;
            if (flush || taken) begin
                pend_q <= 1'b0;
            end else begin
                pend_q <= live_o;
            end
        end
    end

endmodule

// File: rtl/irq_mask_arbiter.sv
module irq_mask_arbiter #(
    parameter int          NUM_SRC  = 6,
    parameter int          XLEN     = 32,
    parameter logic [31:0] VEC_BASE = 32'h80,
    parameter logic [31:0] VEC_STEP = 32'h10
) (
    input  logic [NUM_SRC-1:0] req,
    output logic [NUM_SRC-1:0] grant_o,
    output logic               any_o,
    output logic [XLEN-1:0]    code_o
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC:0]   seen;
    logic [IDX_W-1:0]   idx;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
        assign grant_o[g] = req[g] & ~seen[g];
        assign seen[g+1]  = seen[g] | req[g];
    end

    assign any_o = seen[NUM_SRC];

    always_comb begin
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign code_o = XLEN'(VEC_BASE) + XLEN'(VEC_STEP) * XLEN'(idx);

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_entry_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reset_req,
    input  logic         nmi_live,
    input  logic         mi_any,
    input  logic         psw_np,
    input  logic         psw_id,
    output entry_state_e next_o,
    output entry_state_e state_o,
    output logic         redirect_o
);

    entry_state_e state_q;
    entry_state_e state_d;

    always_comb begin
        if (reset_req) begin
            state_d = ST_RESET;
        end else if (nmi_live && !psw_np) begin
            state_d = ST_NMI;
        end else if (mi_any && !psw_np && !psw_id) begin
            state_d = ST_MASKABLE;
        end else begin
            state_d = ST_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:      redirect_o = 1'b0;
            ST_RESET:    redirect_o = 1'b1;
            ST_NMI:      redirect_o = 1'b1;
            ST_MASKABLE: redirect_o = 1'b1;
            default:     redirect_o = 1'b0;
        endcase
    end

    assign next_o  = state_d;
    assign state_o = state_q;

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int          XLEN        = 32,
    parameter int          NUM_SRC     = 6,
    parameter logic [31:0] RESET_VEC   = 32'h0,
    parameter logic [31:0] NMI_VEC     = 32'h10,
    parameter logic [31:0] NMI_CAUSE   = 32'h10,
    parameter logic [31:0] MI_VEC_BASE = 32'h80,
    parameter logic [31:0] MI_VEC_STEP = 32'h10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reset_req,
    input  logic               nmi_req,
    input  logic               nmi_ret,
    input  logic [NUM_SRC-1:0] mi_req,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic               psw_wr_en,
    input  logic [7:0]         psw_wr_data,
    output logic               redirect_o,
    output logic [XLEN-1:0]    target_pc_o,
    output logic [7:0]         psw_o,
    output logic [XLEN-1:0]    ecr_o,
    output logic [XLEN-1:0]    eipc_o,
    output logic [7:0]         eipsw_o,
    output logic [XLEN-1:0]    fepc_o,
    output logic [7:0]         fepsw_o,
    output logic [NUM_SRC-1:0] mi_ack_o
);

    localparam int HALF = XLEN / 2;

    logic               nmi_live;
    logic [NUM_SRC-1:0] grant;
    logic               mi_any;
    logic [XLEN-1:0]    mi_code;
    entry_state_e       next_st;
    entry_state_e       cur_st;

    logic [XLEN-1:0]    target_q, ecr_q, eipc_q, fepc_q;
    logic [PSW_W-1:0]   psw_q, eipsw_q, fepsw_q, psw_plain;
    logic [NUM_SRC-1:0] ack_q;

    irq_nmi_pending u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_req (nmi_req),
        .taken   (next_st == ST_NMI),
        .flush   (reset_req),
        .live_o  (nmi_live)
    );

    irq_mask_arbiter #(
        .NUM_SRC  (NUM_SRC),
        .XLEN     (XLEN),
        .VEC_BASE (MI_VEC_BASE),
        .VEC_STEP (MI_VEC_STEP)
    ) u_arb (
        .req     (mi_req),
        .grant_o (grant),
        .any_o   (mi_any),
        .code_o  (mi_code)
    );

    irq_entry_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .reset_req  (reset_req),
        .nmi_live   (nmi_live),
        .mi_any     (mi_any),
        .psw_np     (psw_q[PSW_NP]),
        .psw_id     (psw_q[PSW_ID]),
        .next_o     (next_st),
        .state_o    (cur_st),
        .redirect_o (redirect_o)
    );

    // status word update for a cycle without entry: write first, then return strobe
    always_comb begin
        psw_plain = psw_wr_en ? psw_wr_data : psw_q;
        if (nmi_ret) begin
            psw_plain[PSW_NP] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target_q <= XLEN'(RESET_VEC);
            psw_q    <= PSW_RESET;
            ecr_q    <= '0;
            eipc_q   <= '0;
            eipsw_q  <= '0;
            fepc_q   <= '0;
            fepsw_q  <= '0;
            ack_q    <= '0;
        end else begin
            ack_q <= '0;
            unique case (next_st)
                ST_RESET: begin
                    target_q <= XLEN'(RESET_VEC);
                    psw_q    <= PSW_RESET;
                    ecr_q    <= '0;
                end
                ST_NMI: begin
                    fepc_q           <= cur_pc;
                    fepsw_q          <= psw_q;
                    ecr_q            <= {{(XLEN-HALF){1'b0}}, ecr_q[HALF-1:0]} | XLEN'(NMI_CAUSE);
                    psw_q            <= psw_q;
                    psw_q[PSW_NP]    <= 1'b1;
                    psw_q[PSW_ID]    <= 1'b1;
                    psw_q[PSW_EP]    <= 1'b0;
                    target_q         <= XLEN'(NMI_VEC);
                end
                ST_MASKABLE: begin
                    eipc_q           <= cur_pc;
                    eipsw_q          <= psw_q;
                    ecr_q            <= {ecr_q[XLEN-1:HALF], mi_code[HALF-1:0]};
                    psw_q            <= psw_q;
                    psw_q[PSW_ID]    <= 1'b1;
                    psw_q[PSW_EP]    <= 1'b0;
                    target_q         <= mi_code;
                    ack_q            <= grant;
                end
                ST_RUN: begin
                    psw_q <= psw_plain;
                end
                default: begin
                    psw_q <= psw_q;
                end
            endcase
        end
    end

    assign target_pc_o = target_q;
    assign psw_o       = psw_q;
    assign ecr_o       = ecr_q;
    assign eipc_o      = eipc_q;
    assign eipsw_o     = eipsw_q;
    assign fepc_o      = fepc_q;
    assign fepsw_o     = fepsw_q;
    assign mi_ack_o    = ack_q;

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk
    import irq_entry_pkg::*;
#(
    parameter int          XLEN        = 32,
    parameter int          NUM_SRC     = 6,
    parameter logic [31:0] RESET_VEC   = 32'h0,
    parameter logic [31:0] NMI_VEC     = 32'h10,
    parameter logic [31:0] NMI_CAUSE   = 32'h10,
    parameter logic [31:0] MI_VEC_BASE = 32'h80,
    parameter logic [31:0] MI_VEC_STEP = 32'h10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reset_req,
    input logic               nmi_req,
    input logic               nmi_ret,
    input logic [NUM_SRC-1:0] mi_req,
    input logic [XLEN-1:0]    cur_pc,
    input logic               psw_wr_en,
    input logic [7:0]         psw_wr_data,
    input logic               redirect_o,
    input logic [XLEN-1:0]    target_pc_o,
    input logic [7:0]         psw_o,
    input logic [XLEN-1:0]    ecr_o,
    input logic [XLEN-1:0]    eipc_o,
    input logic [7:0]         eipsw_o,
    input logic [XLEN-1:0]    fepc_o,
    input logic [7:0]         fepsw_o,
    input logic [NUM_SRC-1:0] mi_ack_o
);

    localparam int HALF = XLEN / 2;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> (redirect_o && target_pc_o == XLEN'(RESET_VEC) &&
                       psw_o == PSW_RESET && ecr_o == '0 && mi_ack_o == '0));

    // R3
    nmi_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psw_o[PSW_NP] && !reset_req) |=> !(redirect_o && target_pc_o == XLEN'(NMI_VEC)));

    // R2
    nmi_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && target_pc_o == XLEN'(NMI_VEC)) |->
            (psw_o[PSW_NP] && psw_o[PSW_ID] && !psw_o[PSW_EP] &&
             ecr_o[XLEN-1:HALF] == '0 && fepc_o == $past(cur_pc) &&
             (ecr_o & XLEN'(NMI_CAUSE)) == XLEN'(NMI_CAUSE)));

    // R5
    mask_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reset_req && (psw_o[PSW_NP] || psw_o[PSW_ID])) |=> (mi_ack_o == '0));

    // R7
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mi_ack_o));

    // R6
    mask_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mi_ack_o != '0) |->
            (redirect_o && psw_o[PSW_ID] && !psw_o[PSW_EP] &&
             ecr_o[HALF-1:0] == target_pc_o[HALF-1:0] &&
             eipc_o == $past(cur_pc) &&
             (mi_ack_o & $past(mi_req)) == mi_ack_o));

    // R10
    context_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_o |-> ($stable(target_pc_o) && $stable(fepc_o) && $stable(eipc_o)));

endmodule

bind irq_entry_ctrl irq_entry_chk #(
    .XLEN        (XLEN),
    .NUM_SRC     (NUM_SRC),
    .RESET_VEC   (RESET_VEC),
    .NMI_VEC     (NMI_VEC),
    .NMI_CAUSE   (NMI_CAUSE),
    .MI_VEC_BASE (MI_VEC_BASE),
    .MI_VEC_STEP (MI_VEC_STEP)
) u_chk (.*);

// File: tb/irq_entry_ctrl_bench.sv
module irq_entry_ctrl_bench;

    localparam int XLEN = 32;
    localparam int NSRC = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reset_req = 1'b0;
    logic             nmi_req = 1'b0;
    logic             nmi_ret = 1'b0;
    logic [NSRC-1:0]  mi_req = '0;
    logic [XLEN-1:0]  cur_pc = '0;
    logic             psw_wr_en = 1'b0;
    logic [7:0]       psw_wr_data = '0;

    logic             redirect_o;
    logic [XLEN-1:0]  target_pc_o, ecr_o, eipc_o, fepc_o;
    logic [7:0]       psw_o, eipsw_o, fepsw_o;
    logic [NSRC-1:0]  mi_ack_o;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    bit  chk_en = 1'b0;
    int  nmi_seen = 0;

    always #2.5 clk = ~clk;

    irq_entry_ctrl u_irq_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .nmi_req(nmi_req),
        .nmi_ret(nmi_ret), .mi_req(mi_req), .cur_pc(cur_pc),
        .psw_wr_en(psw_wr_en), .psw_wr_data(psw_wr_data),
        .redirect_o(redirect_o), .target_pc_o(target_pc_o), .psw_o(psw_o),
        .ecr_o(ecr_o), .eipc_o(eipc_o), .eipsw_o(eipsw_o), .fepc_o(fepc_o),
        .fepsw_o(fepsw_o), .mi_ack_o(mi_ack_o)
    );

    // expected state, computed from the requirements
    logic [XLEN-1:0] m_pc, m_ecr, m_eipc, m_fepc;
    logic [7:0]      m_psw, m_eipsw, m_fepsw;
    logic [NSRC-1:0] m_ack;
    logic            m_redir, m_pend, m_prev;
    string           m_tag = "R1";

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pc = 0; m_psw = 8'h20; m_ecr = 0; m_eipc = 0; m_eipsw = 0;
            m_fepc = 0; m_fepsw = 0; m_ack = 0; m_redir = 0; m_pend = 0;
            m_prev = 0; m_tag = "R1";
        end else begin
            logic live;
            live   = m_pend | (nmi_req & ~m_prev);
            m_prev = nmi_req;
            m_ack  = 0;
            if (reset_req) begin                                     // R1, R8
                m_pc = 0; m_psw = 8'h20; m_ecr = 0; m_pend = 0; m_redir = 1;
                m_tag = "R8";
            end else if (live && !m_psw[7]) begin                    // R2
                m_fepc = cur_pc; m_fepsw = m_psw;
                m_ecr  = {16'h0, m_ecr[15:0]} | 32'h10;
                m_psw  = (m_psw | 8'hA0) & 8'hBF;
                m_pc   = 32'h10; m_pend = 0; m_redir = 1;
                m_tag  = "R2";
            end else if (mi_req != 0 && !m_psw[7] && !m_psw[5]) begin // R6, R7
                int w;
                w = 0;
                for (int i = NSRC - 1; i >= 0; i--) if (mi_req[i]) w = i;
                m_eipc = cur_pc; m_eipsw = m_psw;
                m_psw  = (m_psw | 8'h20) & 8'hBF;
                m_pc   = 32'h80 + 32'h10 * w;
                m_ecr  = {m_ecr[31:16], m_pc[15:0]};
                m_ack  = NSRC'(1) << w;
                m_pend = live; m_redir = 1;
                m_tag  = "R7";
            end else begin                                           // R3, R4, R5, R9
                m_pend = live; m_redir = 0;
                if (psw_wr_en) m_psw = psw_wr_data;
                if (nmi_ret) m_psw[7] = 1'b0;
                m_tag = "R4";
            end
        end
    end

    task automatic check(input string tag, input string what,
                         input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en && rst_n) begin
            check(m_tag, "redirect", XLEN'(redirect_o), XLEN'(m_redir));   // R10
            check(m_tag, "target",   target_pc_o, m_pc);
            check(m_tag, "psw",      XLEN'(psw_o), XLEN'(m_psw));
            check(m_tag, "ecr",      ecr_o, m_ecr);
            check(m_tag, "eipc",     eipc_o, m_eipc);
            check(m_tag, "eipsw",    XLEN'(eipsw_o), XLEN'(m_eipsw));
            check(m_tag, "fepc",     fepc_o, m_fepc);
            check(m_tag, "fepsw",    XLEN'(fepsw_o), XLEN'(m_fepsw));
            check(m_tag, "ack",      XLEN'(mi_ack_o), XLEN'(m_ack));     // R6
            if (redirect_o && target_pc_o == 32'h10) nmi_seen++;
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        // R1: asynchronous reset state
        check("R1", "rst target", target_pc_o, 32'h0);
        check("R1", "rst psw", XLEN'(psw_o), 32'h20);
        check("R1", "rst ecr", ecr_o, 32'h0);
        check("R1", "rst redirect", XLEN'(redirect_o), 32'h0);
        rst_n  = 1'b1;
        chk_en = 1'b1;
        step();

        // near-exhaustive sweep: NP/ID combinations x all maskable patterns x NMI
        for (int p = 0; p < 4; p++) begin
            for (int r = 0; r < 64; r++) begin
                for (int n = 0; n < 2; n++) begin
                    psw_wr_en   = 1'b1;                              // R9
                    psw_wr_data = {p[1], 1'b1, p[0], r[4:0]};
                    step();
                    psw_wr_en = 1'b0;
                    mi_req    = NSRC'(r);                            // R5, R6, R7
                    nmi_req   = n[0];                                // R2, R3, R8
                    cur_pc    = 32'h1000 + 32'(((p * 64 + r) * 2 + n) * 4);
                    step();
                    mi_req  = '0;
                    nmi_req = 1'b0;
                    nmi_ret = 1'b1;                                  // R4
                    step();
                    nmi_ret = 1'b0;
                    step();
                end
            end
        end

        // R3: repeated rising edges while NP is set merge into one entry
        psw_wr_en = 1'b1; psw_wr_data = 8'h80; step();
        psw_wr_en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            nmi_req = 1'b1; step();
            nmi_req = 1'b0; step();
        end
        nmi_seen = 0;
        nmi_ret = 1'b1; step();
        nmi_ret = 1'b0;
        repeat (6) step();
        check("R3", "merged nmi entries", XLEN'(nmi_seen), 32'd1);

        // R8: reset beats NMI and every maskable source
        psw_wr_en = 1'b1; psw_wr_data = 8'h00; step();
        psw_wr_en = 1'b0;
        reset_req = 1'b1; nmi_req = 1'b1; mi_req = '1; step();
        reset_req = 1'b0; nmi_req = 1'b0; mi_req = '0;
        check("R8", "reset wins target", target_pc_o, 32'h0);
        check("R8", "reset wins ack", XLEN'(mi_ack_o), 32'h0);
        step();

        // R4: psw write dropped on an entry edge
        psw_wr_en = 1'b1; psw_wr_data = 8'h00; step();
        mi_req = 6'b100000; psw_wr_data = 8'h0F; step();
        psw_wr_en = 1'b0; mi_req = '0;
        check("R4", "write dropped on entry", XLEN'(psw_o), 32'h20);
        check("R7", "last source code", target_pc_o, 32'hD0);
        step();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule